// File: doc/BRIEF.md
# Fractional-Prescaled Reload Baud Generator

This block makes the bit-rate timing enables for a serial channel that runs in either an asynchronous (oversampled) mode or a synchronous mode. A prescaler sits in front of a 13-bit down-counting reload timer. The prescaler is either a fixed divide-by-2 or divide-by-3 stage, or a fractional stage that passes n out of every 512 input cycles. Each time the timer underflows it emits one enable pulse and reloads from a separate reload register. The underflow pulses are then divided by 16 (asynchronous) or 4 (synchronous) to form the bit-clock enable. In asynchronous mode the block also marks the three majority-vote sample points inside each bit.

Software-style control arrives as plain inputs: a write strobe and a 16-bit data word for the reload value, a run level, a fixed-ratio select, a fractional-enable select, a 9-bit fractional value and a mode select. The read port always shows the live timer count. Every write also reloads the timer. If the timer is stopped when the write happens, that reload waits until the first running cycle.

Top module: `baud_rate_gen`

## Requirements
- R1: While running, the timer counts down by one on each prescaler enable. On an enable that finds the timer at 0, `timerTick` pulses for that cycle and the timer loads the reload register, so the underflow period is (reload+1) prescaler enables.
- R2: While `runBit` is 0, the timer, the prescaler state and the bit phase hold, and `timerTick`, `bitTick` and `sampleTick` stay 0.
- R3: A write stores `regWrData[12:0]` as the reload value and ignores bits 15 to 13. `regRdData` always returns the current timer count in bits 12:0, with bits 15:13 reading 0.
- R4: A write while `runBit` is 1 puts the written 13-bit value into the timer on the next clock.
- R5: A write while `runBit` is 0 leaves the timer unchanged. In the first cycle in which `runBit` is 1, the timer loads the reload register.
- R6: With the fractional stage inactive, the prescaler enables once every 2 running cycles when `brsSel` is 0 and once every 3 when `brsSel` is 1.
- R7: With `fdeSel`=1 in asynchronous mode, a 9-bit accumulator adds `fracN` on each running cycle and enables whenever the sum reaches 512 or more. `fracN`=0 gives no enables.
- R8: In synchronous mode (`syncMode`=1), `fdeSel` has no effect and the fixed prescaler is used.
- R9: `bitTick` pulses on every 16th underflow in asynchronous mode and every 4th in synchronous mode. Any reload write restarts this count.
- R10: In asynchronous mode, `sampleTick[0]`, `[1]` and `[2]` pulse with the 7th, 8th and 9th underflow of each bit. In synchronous mode they never pulse.
- R11: During reset and right after it, the timer, the reload register, the prescaler state and the bit phase are all 0, and all outputs are 0.
- R12: When a write and an underflow fall in the same cycle, `timerTick` still pulses and the timer takes the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runBit | input | 1 | Timer run control |
| regWrEn | input | 1 | Reload register write strobe |
| regWrData | input | 16 | Write data; bits 12:0 used |
| regRdData | output | 16 | Live timer count, upper three bits zero |
| brsSel | input | 1 | Fixed ratio select: 0 = /2, 1 = /3 |
| fdeSel | input | 1 | Fractional prescaler select (asynchronous only) |
| fracN | input | 9 | Fractional numerator n of n/512 |
| syncMode | input | 1 | 1 = synchronous (/4), 0 = asynchronous (/16) |
| timerTick | output | 1 | Timer underflow enable |
| bitTick | output | 1 | Bit-clock enable |
| sampleTick | output | 3 | Asynchronous sample-point strobes (7th, 8th, 9th) |

## Verification
The bench targets reload writes made while stopped. A design that reloads at once, or never reloads, shows a wrong read count in the first running cycle. It drives writes in back-to-back cycles so that one lands on an underflow: a design that gives the old reload value priority, or drops the pulse, diverges from the model at once. It also sweeps fractional values of 0, 1, 300 and 511 and turns on the fractional select in synchronous mode. A wrong accumulator carry or an unmasked select changes the underflow spacing. Sample strobes and bit ticks are compared in both modes, which exposes off-by-one sample positions and a wrong divider modulus.

// File: rtl/brg_pkg.sv
package brg_pkg;
  // Strobes the control side hands to the timer datapath each cycle.
  typedef struct packed {
    logic advance;    // prescaler enable gated by run
    logic load;       // timer must take a load value this cycle
    logic useWrData;  // load value comes from the write port
  } brg_strobe_t;
endpackage

// File: rtl/brg_ctrl.sv
module brg_ctrl
  import brg_pkg::*;
#(
  parameter int FRAC_W = 9,
  parameter int FIX_LO = 2,
  parameter int FIX_HI = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runBit,
  input  logic              regWrEn,
  input  logic              fdeSel,
  input  logic              brsSel,
  input  logic              syncMode,
  input  logic [FRAC_W-1:0] fracN,
  output brg_strobe_t       strobe
);
  localparam int PRE_W = $clog2(FIX_HI + 1);
  localparam logic [PRE_W-1:0] LAST_LO = PRE_W'(FIX_LO - 1);
  localparam logic [PRE_W-1:0] LAST_HI = PRE_W'(FIX_HI - 1);

  logic [FRAC_W-1:0] fracAcc;
  logic [FRAC_W:0]   fracSum;
  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  preLast;
  logic              fracActive;
  logic              fracEn;
  logic              fixEn;
  logic              divEn;
  logic              pendLoad;

  // Fractional stage is only honoured in asynchronous mode.
  assign fracActive = fdeSel & ~syncMode;
  assign fracSum    = {1'b0, fracAcc} + {1'b0, fracN};
  assign fracEn     = fracSum[FRAC_W];
  assign preLast    = brsSel ? LAST_HI : LAST_LO;
  assign fixEn      = (preCnt >= preLast);
  assign divEn      = fracActive ? fracEn : fixEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fracAcc <= '0;
      preCnt  <= '0;
    end else if (runBit) begin
      if (fracActive) fracAcc <= fracSum[FRAC_W-1:0];
      else            preCnt  <= fixEn ? '0 : preCnt + 1'b1;
    end
  end

  // Reload requested while stopped waits for the first running cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   pendLoad <= 1'b0;
    else if (regWrEn && !runBit) pendLoad <= 1'b1;
    else if (runBit)             pendLoad <= 1'b0;
  end

  assign strobe.advance   = runBit & divEn;
  assign strobe.load      = runBit & (regWrEn | pendLoad);
  assign strobe.useWrData = regWrEn;

  p_no_advance_stopped_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runBit |-> !strobe.advance);
  p_pending_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !runBit) |=> pendLoad);
  p_pending_applies_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pendLoad && runBit) |-> strobe.load);
  p_frac_zero_silent_r7: assert property (@(posedge clk) disable iff (!rstN)
    (fracActive && fracN == '0) |-> !divEn);
  p_fixed_in_sync_r8: assert property (@(posedge clk) disable iff (!rstN)
    syncMode |-> (divEn == fixEn));
endmodule

// File: rtl/brg_datapath.sv
module brg_datapath
  import brg_pkg::*;
#(
  parameter int TIMER_W    = 13,
  parameter int OVS_ASYNC  = 16,
  parameter int DIV_SYNC   = 4,
  parameter int NUM_SAMP   = 3,
  parameter int FIRST_SAMP = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  brg_strobe_t        strobe,
  input  logic               regWrEn,
  input  logic [TIMER_W-1:0] wrValue,
  input  logic               syncMode,
  output logic [TIMER_W-1:0] timerCount,
  output logic               timerTick,
  output logic               bitTick,
  output logic [NUM_SAMP-1:0] sampleTick
);
  localparam int PH_W = $clog2(OVS_ASYNC);
  localparam logic [PH_W-1:0] LAST_ASYNC = PH_W'(OVS_ASYNC - 1);
  localparam logic [PH_W-1:0] LAST_SYNC  = PH_W'(DIV_SYNC - 1);

  logic [TIMER_W-1:0] timer;
  logic [TIMER_W-1:0] reloadReg;
  logic [TIMER_W-1:0] loadVal;
  logic [PH_W-1:0]    phase;
  logic [PH_W-1:0]    phaseLast;
  logic               phaseWrap;
  logic               underflow;

  assign underflow = strobe.advance && (timer == '0);
  assign loadVal   = strobe.useWrData ? wrValue : reloadReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        reloadReg <= '0;
    else if (regWrEn) reloadReg <= wrValue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               timer <= '0;
    else if (strobe.load)    timer <= loadVal;
    else if (underflow)      timer <= reloadReg;
    else if (strobe.advance) timer <= timer - 1'b1;
  end

  // Bit phase: counts underflows within one bit period.
  assign phaseLast = syncMode ? LAST_SYNC : LAST_ASYNC;
  assign phaseWrap = (phase >= phaseLast);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          phase <= '0;
    else if (regWrEn)   phase <= '0;
    else if (underflow) phase <= phaseWrap ? '0 : phase + 1'b1;
  end

  assign timerTick  = underflow;
  assign bitTick    = underflow & phaseWrap;
  assign timerCount = timer;

  for (genvar k = 0; k < NUM_SAMP; k++) begin : g_samp
    assign sampleTick[k] = underflow & ~syncMode & (phase == PH_W'(FIRST_SAMP + k));
  end

  p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.advance && !strobe.load) |=> $stable(timer));
  p_reload_on_underflow_r1: assert property (@(posedge clk) disable iff (!rstN)
    (timerTick && !strobe.load) |=> (timer == $past(reloadReg)));
  p_write_loads_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.useWrData) |=> (timer == $past(wrValue)));
  p_bit_on_underflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    bitTick |-> timerTick);
  p_one_sample_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sampleTick));
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import brg_pkg::*;
#(
  parameter int PORT_W     = 16,
  parameter int TIMER_W    = 13,
  parameter int FRAC_W     = 9,
  parameter int FIX_LO     = 2,
  parameter int FIX_HI     = 3,
  parameter int OVS_ASYNC  = 16,
  parameter int DIV_SYNC   = 4,
  parameter int NUM_SAMP   = 3,
  parameter int FIRST_SAMP = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runBit,
  input  logic                regWrEn,
  input  logic [PORT_W-1:0]   regWrData,
  output logic [PORT_W-1:0]   regRdData,
  input  logic                brsSel,
  input  logic                fdeSel,
  input  logic [FRAC_W-1:0]   fracN,
  input  logic                syncMode,
  output logic                timerTick,
  output logic                bitTick,
  output logic [NUM_SAMP-1:0] sampleTick
);
  localparam int PAD_W = PORT_W - TIMER_W;

  brg_strobe_t        strobe;
  logic [TIMER_W-1:0] timerCount;
  logic               unusedWrHi;

  assign unusedWrHi = ^regWrData[PORT_W-1:TIMER_W];

  brg_ctrl #(.FRAC_W(FRAC_W), .FIX_LO(FIX_LO), .FIX_HI(FIX_HI)) ctrl_i (
    .clk(clk), .rstN(rstN), .runBit(runBit), .regWrEn(regWrEn),
    .fdeSel(fdeSel), .brsSel(brsSel), .syncMode(syncMode), .fracN(fracN),
    .strobe(strobe)
  );

  brg_datapath #(.TIMER_W(TIMER_W), .OVS_ASYNC(OVS_ASYNC), .DIV_SYNC(DIV_SYNC),
                 .NUM_SAMP(NUM_SAMP), .FIRST_SAMP(FIRST_SAMP)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn),
    .wrValue(regWrData[TIMER_W-1:0]), .syncMode(syncMode),
    .timerCount(timerCount), .timerTick(timerTick), .bitTick(bitTick),
    .sampleTick(sampleTick)
  );

  assign regRdData = {{PAD_W{1'b0}}, timerCount};

  p_read_top_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[PORT_W-1:TIMER_W] == '0);
endmodule

// File: tb/baud_rate_gen_tb_top.sv
`timescale 1ns/100ps
module baud_rate_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runBit = 1'b0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        brsSel = 1'b0;
  logic        fdeSel = 1'b0;
  logic [8:0]  fracN = '0;
  logic        syncMode = 1'b0;
  logic        timerTick;
  logic        bitTick;
  logic [2:0]  sampleTick;

  int checks = 0;
  int fails = 0;
  string curReq = "R11";

  // Behavioural reference state
  int mTimer = 0, mReload = 0, mPend = 0, mPre = 0, mAcc = 0, mPhase = 0;

  always #2.5 clk = ~clk;

  baud_rate_gen dut_i (
    .clk(clk), .rstN(rstN), .runBit(runBit), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .brsSel(brsSel),
    .fdeSel(fdeSel), .fracN(fracN), .syncMode(syncMode),
    .timerTick(timerTick), .bitTick(bitTick), .sampleTick(sampleTick)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // One clock: apply write inputs, compare outputs against the model,
  // then advance the model at the edge.
  task automatic step(input bit wr, input logic [15:0] wd);
    bit fracAct, divEn, adv, tk, bt, load;
    int lim, last, eSamp, nxt;
    regWrEn = wr;
    regWrData = wd;
    #1;
    fracAct = fdeSel && !syncMode;
    lim = brsSel ? 2 : 1;
    divEn = fracAct ? ((mAcc + int'(fracN)) >= 512) : (mPre >= lim);
    adv = runBit && divEn;
    tk = adv && (mTimer == 0);
    last = syncMode ? 3 : 15;
    bt = tk && (mPhase >= last);
    eSamp = 0;
    for (int k = 0; k < 3; k++)
      if (tk && !syncMode && mPhase == 6 + k) eSamp = 1 << k;
    chk(timerTick == tk, curReq, "timerTick", int'(timerTick), int'(tk));
    chk(bitTick == bt, curReq, "bitTick", int'(bitTick), int'(bt));
    chk(int'(sampleTick) == eSamp, curReq, "sampleTick", int'(sampleTick), eSamp);
    chk(int'(regRdData) == mTimer, curReq, "regRdData", int'(regRdData), mTimer);
    @(posedge clk);
    load = runBit && (wr || mPend != 0);
    if (load) nxt = wr ? int'(wd) % 8192 : mReload;
    else if (tk) nxt = mReload;
    else if (adv) nxt = mTimer - 1;
    else nxt = mTimer;
    if (runBit) begin
      if (fracAct) mAcc = (mAcc + int'(fracN)) % 512;
      else mPre = (mPre >= lim) ? 0 : mPre + 1;
    end
    if (wr && !runBit) mPend = 1;
    else if (runBit) mPend = 0;
    if (wr) mPhase = 0;
    else if (tk) mPhase = (mPhase >= last) ? 0 : mPhase + 1;
    if (wr) mReload = int'(wd) % 8192;
    mTimer = nxt;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R11: outputs zero while in reset
    repeat (3) @(negedge clk);
    chk(regRdData == 16'h0, "R11", "reset read", int'(regRdData), 0);
    chk(!timerTick && !bitTick && sampleTick == 3'b000, "R11", "reset strobes",
        int'({timerTick, bitTick, sampleTick}), 0);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R11"; idle(4);

    // R2: stopped block stays silent
    curReq = "R2"; idle(10);

    // R6: fixed ratios with a small reload written while running (R4)
    runBit = 1'b1;
    curReq = "R4"; step(1'b1, 16'h0003); idle(3);
    curReq = "R6"; brsSel = 1'b0; idle(60);
    brsSel = 1'b1; idle(60);

    // R3: upper write bits ignored
    curReq = "R3"; step(1'b1, 16'hE005); idle(40);

    // R5: write while stopped, then restart
    curReq = "R5"; runBit = 1'b0; idle(2);
    step(1'b1, 16'h0009); idle(5);
    runBit = 1'b1; idle(60);

    // R2: stop mid count, then resume
    curReq = "R2"; runBit = 1'b0; idle(12);
    runBit = 1'b1; idle(20);

    // R12: back-to-back writes so one lands on an underflow
    curReq = "R12"; brsSel = 1'b0; step(1'b1, 16'h0000); idle(1);
    for (int i = 0; i < 8; i++) step(1'b1, 16'(i % 3));
    idle(10);

    // R9 and R10: asynchronous bit and sample strobes, reload 0
    curReq = "R10"; step(1'b1, 16'h0000); idle(150);
    curReq = "R9"; syncMode = 1'b1; idle(60);

    // R8: fractional select ignored in synchronous mode
    curReq = "R8"; fdeSel = 1'b1; fracN = 9'd100; step(1'b1, 16'h0001); idle(80);

    // R7: fractional stage in asynchronous mode
    curReq = "R7"; syncMode = 1'b0;
    fracN = 9'd0; idle(40);
    fracN = 9'd300; idle(150);
    fracN = 9'd511; idle(80);
    fracN = 9'd1; step(1'b1, 16'h0000); idle(1100);

    // R1: longer reload under fixed prescaler
    curReq = "R1"; fdeSel = 1'b0; brsSel = 1'b1; step(1'b1, 16'h0004); idle(200);

    finish_run();
  end
endmodule